// File: doc/BRIEF.md
# Programmable Interlaced Sync Generator

This block is a master-mode timing source for interlaced video. It runs a pixel counter and a line counter. From a set of configuration inputs it produces five timing outputs: horizontal sync, horizontal valid, vertical sync, vertical valid and a field indicator. Each edge position can be programmed.

Horizontal sync and horizontal valid are pixel windows along every line. Vertical valid is a line window for each field. Vertical sync and the field indicator do not switch at a line boundary. Each of them switches at a programmable number of cycles after the point where horizontal valid ends. Each field has its own start line, end line and offset. An offset that reaches past the end of the line carries into the next line.

All configuration is captured into shadow storage only at the frame boundary. A frame therefore never mixes old and new timing. A polarity word sets the active level of each output. A launch-edge select can move every output, including the counters, onto the falling clock edge.

Two small state machines drive vertical sync and the field indicator. The vertical sync machine has the states VS_IDLE and VS_PULSE. It moves from VS_IDLE to VS_PULSE on the start event of either field, and from VS_PULSE to VS_IDLE on the end event of either field. The field machine has the states FLD_SECOND and FLD_FIRST. It moves from FLD_SECOND to FLD_FIRST on the first-field event, and from FLD_FIRST to FLD_SECOND on the second-field event. After reset the machines sit in VS_IDLE and FLD_SECOND, because line 1 belongs to the tail of the previous frame's second field.

Top module: `isg_sync_gen`

## Requirements
- R1: The pixel count runs from 0 to H_TOTAL-1. The line count runs from 1 to V_TOTAL. The line count advances when the pixel count wraps, and both counters wrap together at the end of the frame.
- R2: Horizontal sync is active for pixel positions p with hs_start <= p < hs_end.
- R3: Horizontal valid is active for hact_start <= p < hact_end. Vertical valid is active on lines from va1_first to va1_last and from va2_first to va2_last, both ends included.
- R4: Vertical sync becomes active at line vs1_on_line, at pixel hact_end + vs1_ofs, and becomes inactive at line vs1_off_line at the same pixel. Field two follows the same rule with its own lines and offset (vs2_*).
- R5: When hact_end plus an offset is H_TOTAL or more, the event falls on the following line, at pixel (hact_end + offset - H_TOTAL).
- R6: The field indicator takes the first-field level from line fld1_line, at pixel hact_end + fld_ofs, with the R5 wrap. It takes the second-field level from line fld2_line at the same pixel offset. After reset it shows the second-field level.
- R7: Polarity word: bit0 = 1 makes horizontal valid active high. Bit1 = 0 makes horizontal sync active high. Bit2 = 1 makes vertical valid active high. Bit3 = 0 makes vertical sync active high. Bit4 is the field output level during the first field, and the inverse of bit4 is the level during the second field.
- R8: With clk_inv = 0, all outputs change on the rising clock edge. With clk_inv = 1, all outputs change on the following falling edge and carry the same values half a cycle later.
- R9: Configuration inputs take effect only from the first pixel of the next frame. Until the first frame boundary the RST_CFG parameter values apply.
- R10: While reset is held, every output reads 0. After release, the outputs after rising edge n show position n-1 of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hs_start | input | CW | First pixel of horizontal sync |
| cfg_hs_end | input | CW | First pixel after horizontal sync |
| cfg_hact_start | input | CW | First pixel of horizontal valid |
| cfg_hact_end | input | CW | First pixel after horizontal valid; base for the offsets |
| cfg_vs1_on_line | input | CW | Field-one vertical sync start line |
| cfg_vs1_off_line | input | CW | Field-one vertical sync end line |
| cfg_vs1_ofs | input | CW | Field-one vertical sync offset after hact_end |
| cfg_vs2_on_line | input | CW | Field-two vertical sync start line |
| cfg_vs2_off_line | input | CW | Field-two vertical sync end line |
| cfg_vs2_ofs | input | CW | Field-two vertical sync offset after hact_end |
| cfg_fld1_line | input | CW | Line on which the first field begins |
| cfg_fld2_line | input | CW | Line on which the second field begins |
| cfg_fld_ofs | input | CW | Field indicator offset after hact_end |
| cfg_va1_first | input | CW | First valid line of field one |
| cfg_va1_last | input | CW | Last valid line of field one |
| cfg_va2_first | input | CW | First valid line of field two |
| cfg_va2_last | input | CW | Last valid line of field two |
| cfg_polarity | input | 5 | Polarity word (R7) |
| cfg_clk_inv | input | 1 | Launch outputs on the falling edge |
| hsync_o | output | 1 | Horizontal sync |
| hvalid_o | output | 1 | Horizontal valid |
| vsync_o | output | 1 | Vertical sync |
| vvalid_o | output | 1 | Vertical valid |
| field_o | output | 1 | Field indicator |
| pix_cnt_o | output | HW | Pixel position of the current outputs |
| line_cnt_o | output | VW | Line number of the current outputs |

## Verification
There is one register between the internal counters and the outputs. After rising edge n, the outputs therefore describe frame position n-1. With the falling-edge launch, they show the same values half a clock cycle later. The bench model advances one position on each rising edge and checks twice per cycle. At 5 ns after the edge it expects the previous position when clk_inv is set, and the current position otherwise. At 15 ns after the edge it always expects the current position. A configuration change is predicted to show up at position 0 of the frame after the write, so every cycle before that boundary still checks the old settings.

// File: rtl/isg_pkg.sv
package isg_pkg;

    localparam int CW = 12;

    typedef struct packed {
        logic [CW-1:0] hs_start;
        logic [CW-1:0] hs_end;
        logic [CW-1:0] hact_start;
        logic [CW-1:0] hact_end;
        logic [CW-1:0] vs1_on;
        logic [CW-1:0] vs1_off;
        logic [CW-1:0] vs1_ofs;
        logic [CW-1:0] vs2_on;
        logic [CW-1:0] vs2_off;
        logic [CW-1:0] vs2_ofs;
        logic [CW-1:0] fld1_line;
        logic [CW-1:0] fld2_line;
        logic [CW-1:0] fld_ofs;
        logic [CW-1:0] va1_first;
        logic [CW-1:0] va1_last;
        logic [CW-1:0] va2_first;
        logic [CW-1:0] va2_last;
        logic [4:0]    pol;
        logic          clk_inv;
    } isg_cfg_t;

    localparam isg_cfg_t ISG_CFG_DEFAULT = '{
        hs_start:   CW'(28),
        hs_end:     CW'(159),
        hact_start: CW'(122),
        hact_end:   CW'(842),
        vs1_on:     CW'(3),
        vs1_off:    CW'(7),
        vs1_ofs:    CW'(90),
        vs2_on:     CW'(265),
        vs2_off:    CW'(268),
        vs2_ofs:    CW'(855),
        fld1_line:  CW'(3),
        fld2_line:  CW'(265),
        fld_ofs:    CW'(31),
        va1_first:  CW'(21),
        va1_last:   CW'(262),
        va2_first:  CW'(284),
        va2_last:   CW'(524),
        pol:        5'b00101,
        clk_inv:    1'b0
    };

    typedef enum logic {VS_IDLE, VS_PULSE} vs_state_t;
    typedef enum logic {FLD_SECOND, FLD_FIRST} fld_state_t;

endpackage

// File: rtl/isg_timebase.sv
module isg_timebase #(
    parameter int H_TOTAL = 858,
    parameter int V_TOTAL = 525,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          frame_end
);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= VW'(1);
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_LAST) ? VW'(1) : vcnt + VW'(1);
        end else begin
            hcnt <= hcnt + HW'(1);
        end
    end

    assign frame_end = (hcnt == H_LAST) && (vcnt == V_LAST);

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == H_LAST && vcnt != V_LAST) |=> (hcnt == '0 && vcnt == $past(vcnt) + VW'(1))); // R1
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt != H_LAST) |=> $stable(vcnt)); // R1

endmodule

// File: rtl/isg_shadow.sv
module isg_shadow
    import isg_pkg::*;
#(
    parameter isg_cfg_t RST_CFG = ISG_CFG_DEFAULT
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_end,
    input  isg_cfg_t cfg_in,
    output isg_cfg_t cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_q <= RST_CFG;
        else if (frame_end) cfg_q <= cfg_in;
    end

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/isg_vfsm.sv
module isg_vfsm
    import isg_pkg::*;
#(
    parameter int H_TOTAL = 858,
    parameter int V_TOTAL = 525,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL + 1),
    localparam int NEV = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  isg_cfg_t      cfg,
    output logic          vs_next,
    output logic          first_next
);

    // event order: vs1 on, vs1 off, vs2 on, vs2 off, field1, field2
    logic [CW-1:0] ev_line [NEV];
    logic [CW-1:0] ev_ofs  [NEV];
    logic [NEV-1:0] ev_hit;

    always_comb begin
        ev_line[0] = cfg.vs1_on;    ev_ofs[0] = cfg.vs1_ofs;
        ev_line[1] = cfg.vs1_off;   ev_ofs[1] = cfg.vs1_ofs;
        ev_line[2] = cfg.vs2_on;    ev_ofs[2] = cfg.vs2_ofs;
        ev_line[3] = cfg.vs2_off;   ev_ofs[3] = cfg.vs2_ofs;
        ev_line[4] = cfg.fld1_line; ev_ofs[4] = cfg.fld_ofs;
        ev_line[5] = cfg.fld2_line; ev_ofs[5] = cfg.fld_ofs;
    end

    generate
        for (genvar g = 0; g < NEV; g++) begin : g_event
            logic [CW:0]   sum;
            logic          wrap;
            logic [CW:0]   pix;
            logic [CW-1:0] line;
            always_comb begin
                sum  = {1'b0, cfg.hact_end} + {1'b0, ev_ofs[g]};
                wrap = sum >= (CW+1)'(H_TOTAL);
                pix  = wrap ? sum - (CW+1)'(H_TOTAL) : sum;
                if (!wrap)                          line = ev_line[g];
                else if (ev_line[g] == CW'(V_TOTAL)) line = CW'(1);
                else                                line = ev_line[g] + CW'(1);
                ev_hit[g] = (pix == (CW+1)'(hcnt)) && (line == CW'(vcnt));
            end
        end
    endgenerate

    vs_state_t  vs_q, vs_d;
    fld_state_t fld_q, fld_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q  <= VS_IDLE;
            fld_q <= FLD_SECOND;
        end else begin
            vs_q  <= vs_d;
            fld_q <= fld_d;
        end
    end

    always_comb begin
        vs_d = vs_q;
        unique case (vs_q)
            VS_IDLE:  if (ev_hit[0] || ev_hit[2]) vs_d = VS_PULSE;
            VS_PULSE: if (ev_hit[1] || ev_hit[3]) vs_d = VS_IDLE;
        endcase
        fld_d = fld_q;
        unique case (fld_q)
            FLD_SECOND: if (ev_hit[4]) fld_d = FLD_FIRST;
            FLD_FIRST:  if (ev_hit[5]) fld_d = FLD_SECOND;
        endcase
    end

    always_comb begin
        vs_next    = (vs_d == VS_PULSE);
        first_next = (fld_d == FLD_FIRST);
    end

    AST_FIELD_ON_SYNC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fld_q) |-> ($past(CW'(vcnt)) == $past(cfg.fld1_line) ||
                             $past(CW'(vcnt)) == $past(cfg.fld1_line) + CW'(1) ||
                             $past(CW'(vcnt)) == $past(cfg.fld2_line) ||
                             $past(CW'(vcnt)) == $past(cfg.fld2_line) + CW'(1) ||
                             $past(vcnt) == VW'(V_TOTAL))); // R6
    AST_VS_TOGGLE_ON_SYNC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_q == VS_PULSE) |-> ($past(CW'(vcnt)) == $past(cfg.vs1_on) ||
                                     $past(CW'(vcnt)) == $past(cfg.vs1_on) + CW'(1) ||
                                     $past(CW'(vcnt)) == $past(cfg.vs2_on) ||
                                     $past(CW'(vcnt)) == $past(cfg.vs2_on) + CW'(1) ||
                                     $past(vcnt) == VW'(V_TOTAL))); // R4

endmodule

// File: rtl/isg_sync_gen.sv
module isg_sync_gen
    import isg_pkg::*;
#(
    parameter int       H_TOTAL = 858,
    parameter int       V_TOTAL = 525,
    parameter isg_cfg_t RST_CFG = ISG_CFG_DEFAULT,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_hs_start,
    input  logic [CW-1:0] cfg_hs_end,
    input  logic [CW-1:0] cfg_hact_start,
    input  logic [CW-1:0] cfg_hact_end,
    input  logic [CW-1:0] cfg_vs1_on_line,
    input  logic [CW-1:0] cfg_vs1_off_line,
    input  logic [CW-1:0] cfg_vs1_ofs,
    input  logic [CW-1:0] cfg_vs2_on_line,
    input  logic [CW-1:0] cfg_vs2_off_line,
    input  logic [CW-1:0] cfg_vs2_ofs,
    input  logic [CW-1:0] cfg_fld1_line,
    input  logic [CW-1:0] cfg_fld2_line,
    input  logic [CW-1:0] cfg_fld_ofs,
    input  logic [CW-1:0] cfg_va1_first,
    input  logic [CW-1:0] cfg_va1_last,
    input  logic [CW-1:0] cfg_va2_first,
    input  logic [CW-1:0] cfg_va2_last,
    input  logic [4:0]    cfg_polarity,
    input  logic          cfg_clk_inv,
    output logic          hsync_o,
    output logic          hvalid_o,
    output logic          vsync_o,
    output logic          vvalid_o,
    output logic          field_o,
    output logic [HW-1:0] pix_cnt_o,
    output logic [VW-1:0] line_cnt_o
);

    isg_cfg_t      cfg_in, cfg;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          frame_end;
    logic          vs_next, first_next;

    always_comb begin
        cfg_in.hs_start   = cfg_hs_start;
        cfg_in.hs_end     = cfg_hs_end;
        cfg_in.hact_start = cfg_hact_start;
        cfg_in.hact_end   = cfg_hact_end;
        cfg_in.vs1_on     = cfg_vs1_on_line;
        cfg_in.vs1_off    = cfg_vs1_off_line;
        cfg_in.vs1_ofs    = cfg_vs1_ofs;
        cfg_in.vs2_on     = cfg_vs2_on_line;
        cfg_in.vs2_off    = cfg_vs2_off_line;
        cfg_in.vs2_ofs    = cfg_vs2_ofs;
        cfg_in.fld1_line  = cfg_fld1_line;
        cfg_in.fld2_line  = cfg_fld2_line;
        cfg_in.fld_ofs    = cfg_fld_ofs;
        cfg_in.va1_first  = cfg_va1_first;
        cfg_in.va1_last   = cfg_va1_last;
        cfg_in.va2_first  = cfg_va2_first;
        cfg_in.va2_last   = cfg_va2_last;
        cfg_in.pol        = cfg_polarity;
        cfg_in.clk_inv    = cfg_clk_inv;
    end

    isg_timebase #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_timebase (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end)
    );

    isg_shadow #(.RST_CFG(RST_CFG)) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cfg_in(cfg_in), .cfg_q(cfg)
    );

    isg_vfsm #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_vfsm (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .cfg(cfg),
        .vs_next(vs_next), .first_next(first_next)
    );

    // raw active-high windows at the current counter position
    logic [CW-1:0] hpos, vpos;
    logic          hs_raw, hv_raw, vv_raw;
    logic [4:0]    sig_d;

    always_comb begin
        hpos   = CW'(hcnt);
        vpos   = CW'(vcnt);
        hs_raw = (hpos >= cfg.hs_start)   && (hpos < cfg.hs_end);
        hv_raw = (hpos >= cfg.hact_start) && (hpos < cfg.hact_end);
        vv_raw = ((vpos >= cfg.va1_first) && (vpos <= cfg.va1_last)) ||
                 ((vpos >= cfg.va2_first) && (vpos <= cfg.va2_last));
        // order: {field, vsync, vvalid, hsync, hvalid}
        sig_d  = {first_next ? cfg.pol[4] : ~cfg.pol[4],
                  vs_next ^ cfg.pol[3],
                  vv_raw ^ ~cfg.pol[2],
                  hs_raw ^ cfg.pol[1],
                  hv_raw ^ ~cfg.pol[0]};
    end

    logic [4:0]    pos_sig, neg_sig;
    logic [HW-1:0] pos_pix, neg_pix;
    logic [VW-1:0] pos_line, neg_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_sig  <= '0;
            pos_pix  <= '0;
            pos_line <= '0;
        end else begin
            pos_sig  <= sig_d;
            pos_pix  <= hcnt;
            pos_line <= vcnt;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_sig  <= '0;
            neg_pix  <= '0;
            neg_line <= '0;
        end else begin
            neg_sig  <= pos_sig;
            neg_pix  <= pos_pix;
            neg_line <= pos_line;
        end
    end

    always_comb begin
        if (cfg.clk_inv) begin
            {field_o, vsync_o, vvalid_o, hsync_o, hvalid_o} = neg_sig;
            pix_cnt_o  = neg_pix;
            line_cnt_o = neg_line;
        end else begin
            {field_o, vsync_o, vvalid_o, hsync_o, hvalid_o} = pos_sig;
            pix_cnt_o  = pos_pix;
            line_cnt_o = pos_line;
        end
    end

    AST_HALF_CYCLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_sig == pos_sig) && (neg_pix == pos_pix) && (neg_line == pos_line)); // R8

endmodule

// File: tb/isg_sync_gen_bench.sv
`timescale 1ns/1ps
module isg_sync_gen_bench;
    import isg_pkg::*;

    localparam int H = 32;
    localparam int V = 20;
    localparam int F = H * V;
    localparam int NCYC = 2700;

    localparam isg_cfg_t CFG_A = '{
        hs_start: 12'd2,  hs_end: 12'd6,  hact_start: 12'd8, hact_end: 12'd28,
        vs1_on: 12'd3,  vs1_off: 12'd5,  vs1_ofs: 12'd3,
        vs2_on: 12'd12, vs2_off: 12'd14, vs2_ofs: 12'd10,
        fld1_line: 12'd3, fld2_line: 12'd12, fld_ofs: 12'd1,
        va1_first: 12'd4, va1_last: 12'd9, va2_first: 12'd13, va2_last: 12'd19,
        pol: 5'b00101, clk_inv: 1'b0};
    localparam isg_cfg_t CFG_B = '{
        hs_start: 12'd4,  hs_end: 12'd10, hact_start: 12'd6, hact_end: 12'd26,
        vs1_on: 12'd2,  vs1_off: 12'd4,  vs1_ofs: 12'd6,
        vs2_on: 12'd11, vs2_off: 12'd13, vs2_ofs: 12'd2,
        fld1_line: 12'd2, fld2_line: 12'd11, fld_ofs: 12'd0,
        va1_first: 12'd3, va1_last: 12'd8, va2_first: 12'd12, va2_last: 12'd18,
        pol: 5'b11010, clk_inv: 1'b1};
    localparam isg_cfg_t CFG_C = '{
        hs_start: 12'd0,  hs_end: 12'd31, hact_start: 12'd8, hact_end: 12'd28,
        vs1_on: 12'd3,  vs1_off: 12'd5,  vs1_ofs: 12'd3,
        vs2_on: 12'd12, vs2_off: 12'd14, vs2_ofs: 12'd10,
        fld1_line: 12'd3, fld2_line: 12'd12, fld_ofs: 12'd1,
        va1_first: 12'd4, va1_last: 12'd9, va2_first: 12'd13, va2_last: 12'd19,
        pol: 5'b10000, clk_inv: 1'b0};

    typedef struct {
        int         pix;
        int         line;
        logic [4:0] sig;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    isg_cfg_t drv = CFG_A;
    logic hsync, hvalid, vsync, vvalid, field;
    logic [4:0] pix;
    logic [4:0] line;

    always #10 clk = ~clk;

    isg_sync_gen #(.H_TOTAL(H), .V_TOTAL(V), .RST_CFG(CFG_A)) u_isg_sync_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_hs_start(drv.hs_start), .cfg_hs_end(drv.hs_end),
        .cfg_hact_start(drv.hact_start), .cfg_hact_end(drv.hact_end),
        .cfg_vs1_on_line(drv.vs1_on), .cfg_vs1_off_line(drv.vs1_off), .cfg_vs1_ofs(drv.vs1_ofs),
        .cfg_vs2_on_line(drv.vs2_on), .cfg_vs2_off_line(drv.vs2_off), .cfg_vs2_ofs(drv.vs2_ofs),
        .cfg_fld1_line(drv.fld1_line), .cfg_fld2_line(drv.fld2_line), .cfg_fld_ofs(drv.fld_ofs),
        .cfg_va1_first(drv.va1_first), .cfg_va1_last(drv.va1_last),
        .cfg_va2_first(drv.va2_first), .cfg_va2_last(drv.va2_last),
        .cfg_polarity(drv.pol), .cfg_clk_inv(drv.clk_inv),
        .hsync_o(hsync), .hvalid_o(hvalid), .vsync_o(vsync), .vvalid_o(vvalid),
        .field_o(field), .pix_cnt_o(pix), .line_cnt_o(line)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // Expected outputs for one linear frame position under one configuration
    function automatic exp_t model(int pos, isg_cfg_t c);
        exp_t e;
        int p, ln, hend, on1, off1, on2, off2, f1, f2;
        logic hs, hv, vv, vs, first;
        p    = pos % H;
        ln   = pos / H + 1;
        hend = int'(c.hact_end);
        on1  = (int'(c.vs1_on) - 1) * H + hend + int'(c.vs1_ofs);
        off1 = (int'(c.vs1_off) - 1) * H + hend + int'(c.vs1_ofs);
        on2  = (int'(c.vs2_on) - 1) * H + hend + int'(c.vs2_ofs);
        off2 = (int'(c.vs2_off) - 1) * H + hend + int'(c.vs2_ofs);
        f1   = (int'(c.fld1_line) - 1) * H + hend + int'(c.fld_ofs);
        f2   = (int'(c.fld2_line) - 1) * H + hend + int'(c.fld_ofs);
        hs    = (p >= int'(c.hs_start)) && (p < int'(c.hs_end));
        hv    = (p >= int'(c.hact_start)) && (p < hend);
        vv    = (ln >= int'(c.va1_first) && ln <= int'(c.va1_last)) ||
                (ln >= int'(c.va2_first) && ln <= int'(c.va2_last));
        vs    = (pos >= on1 && pos < off1) || (pos >= on2 && pos < off2);
        first = (pos >= f1) && (pos < f2);
        e.pix  = p;
        e.line = ln;
        e.sig[0] = c.pol[0] ? hv : !hv;
        e.sig[1] = c.pol[1] ? !hs : hs;
        e.sig[2] = c.pol[2] ? vv : !vv;
        e.sig[3] = c.pol[3] ? !vs : vs;
        e.sig[4] = first ? c.pol[4] : !c.pol[4];
        return e;
    endfunction

    // Reference model: one frame position per rising edge, shadow loaded at frame end
    int       mpos;
    isg_cfg_t msh;
    exp_t     exp_cur, exp_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            mpos = 0;
            msh  = CFG_A;
            exp_cur  = '{pix: 0, line: 0, sig: 5'b0};
            exp_prev = '{pix: 0, line: 0, sig: 5'b0};
        end else begin
            exp_prev = exp_cur;
            exp_cur  = model(mpos, msh);
            if (mpos == F - 1) msh = drv;
            mpos = (mpos + 1) % F;
        end
    end

    task automatic chk(string tag, int act, int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic compare(exp_t e, string ph);
        chk({"R1 pixel count ", ph}, int'(pix), e.pix);
        chk({"R1 line count ", ph}, int'(line), e.line);
        chk({"R2 R7 hsync ", ph}, int'(hsync), int'(e.sig[1]));
        chk({"R3 R7 hvalid ", ph}, int'(hvalid), int'(e.sig[0]));
        chk({"R3 R7 vvalid ", ph}, int'(vvalid), int'(e.sig[2]));
        chk({"R4 R5 R7 vsync ", ph}, int'(vsync), int'(e.sig[3]));
        chk({"R6 R7 field ", ph}, int'(field), int'(e.sig[4]));
    endtask

    initial begin
        string ph;
        repeat (3) @(posedge clk);
        #15;
        // R10: every output low during reset
        chk("R10 reset hsync", int'(hsync), 0);
        chk("R10 reset hvalid", int'(hvalid), 0);
        chk("R10 reset vsync", int'(vsync), 0);
        chk("R10 reset vvalid", int'(vvalid), 0);
        chk("R10 reset field", int'(field), 0);
        chk("R10 reset pixel", int'(pix), 0);
        chk("R10 reset line", int'(line), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NCYC; k++) begin
            @(posedge clk);
            // R9: between a write and the next frame boundary the old settings must hold
            ph = ((k > 300 && k < F) || (k > 1000 && k < 2 * F)) ? "R9 pending" : "R10 run";
            #5;
            // R8: early sample shows the previous position when launching on the falling edge
            compare(msh.clk_inv ? exp_prev : exp_cur, {ph, " R8 early"});
            #10;
            compare(exp_cur, ph);
            if (k == 300)  drv = CFG_B;
            if (k == 1000) drv = CFG_C;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule